// File: doc/BRIEF.md
# Interrupt-Triggered Descriptor Transfer Engine

This block moves one data unit between memory locations each time an enabled peripheral interrupt fires, without involving the CPU. The transfer parameters do not live in registers. On each request the engine reads a 16-bit pointer from a vector table indexed by the requesting source. It then fetches a four-word control block from RAM at that pointer, performs one byte or word move, and stores the updated addresses and remaining count back into the control block. Finally it pulses a clear line to the requesting peripheral.

A per-source enable vector decides where each request goes. An enabled request is served by the engine. A disabled request is passed through to the CPU as an ordinary interrupt. When a control block's count reaches zero, the engine drops that source's enable. The next request from that source therefore reaches the CPU and signals that the whole job is complete. A typical use is draining a serial receiver into a RAM buffer, one byte per receive-complete event.

The engine owns a simple synchronous memory port for the length of each transfer. It raises a bus request, issues an access only while the bus grant is high, and receives read data one cycle after the access.

Top module: `irq_xfer_engine`

## Requirements
- R1: After reset, bus_req, mem_en and every bit of irq_clr, cpu_irq and en_state are 0, and the engine is idle.
- R2: For source i, the engine reads a 16-bit word at VEC_BASE + 2*i. Memory words are big-endian: the byte at the even address is bits 15:8. That word is the control block address.
- R3: The control block holds four big-endian words at offsets +0, +2, +4 and +6: the mode word, the source address, the destination address and the count. The engine never writes offset +0.
- R4: In the mode word, bit 15 = 1 selects a word unit and 0 a byte unit. Bit 14 = 1 makes the source address increment. Bit 13 = 1 makes the destination address increment. A mode of 0x2000 is byte, fixed source, incrementing destination.
- R5: Each served request moves exactly one unit from the source address to the destination address. A byte move leaves the byte at destination+1 unchanged.
- R6: After the move, an incrementing address advances by 1 for a byte unit and by 2 for a word unit, and a fixed address is unchanged. The count is reduced by 1. The three updated words are written back at offsets +2, +4 and +6.
- R7: Each served request ends with irq_clr asserted for exactly one cycle on the served source's bit only. At most one irq_clr bit is ever high.
- R8: cpu_irq[i] equals irq_req[i] while en_state[i] is 0. A request on a source whose enable is 0 causes no memory access.
- R9: When the written-back count is 0, en_state for that source is cleared in the same cycle as the request is cleared. Otherwise the enable is kept. A later request from that source appears on cpu_irq.
- R10: When several enabled requests are pending while the engine is idle, the lowest source index is served first.
- R11: bus_req stays high from the start of a service until its clear cycle. mem_en is only asserted while bus_gnt is high, and a low grant stalls the sequence without loss.
- R12: A control block with mode 0x2000 and count 0x0080 yields 128 transfers into consecutive destination bytes starting at the programmed base, leaving a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NSRC | Level interrupt requests from peripherals |
| en_wr | input | 1 | Load the enable vector from en_wdata |
| en_wdata | input | NSRC | New enable vector |
| en_state | output | NSRC | Current per-source transfer enables |
| cpu_irq | output | NSRC | Requests passed to the CPU (source not enabled) |
| irq_clr | output | NSRC | One-cycle clear pulse to the served peripheral |
| bus_req | output | 1 | Memory bus request, held for a whole service |
| bus_gnt | input | 1 | Memory bus grant |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_byte | output | 1 | 1 = byte access on bits 7:0, 0 = big-endian word |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read strobe |

## Verification
A corrupted pointer or address register shows on mem_addr within two cycles, because every access is visible on the port. The bench sees it as data landing at the wrong location or a written-back word that differs from the computed update. A wrong count or a wrong mode decode shows at the end of the same service, in the written-back words and in the en_state bit sampled right after the clear pulse. A sequencing fault shows as a missing, doubled or misrouted irq_clr pulse. The bench catches that with a bounded wait, or with cpu_irq rising when a transfer should have taken the request.

// File: rtl/irqx_pkg.sv
// Shared types for the descriptor transfer engine.
// Assumes 16-bit control words stored big-endian in byte-addressed memory.
package irqx_pkg;

    // Mode word bit positions (the control block format depends on them)
    localparam int MODE_WORD_BIT = 15;
    localparam int MODE_SINC_BIT = 14;
    localparam int MODE_DINC_BIT = 13;

    // Byte offsets of the words inside a control block
    localparam int OFS_MODE = 0;
    localparam int OFS_SRC  = 2;
    localparam int OFS_DST  = 4;
    localparam int OFS_CNT  = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VEC,
        ST_MODE,
        ST_SRC,
        ST_DST,
        ST_CNT,
        ST_RDATA,
        ST_WDATA,
        ST_WB_SRC,
        ST_WB_DST,
        ST_WB_CNT,
        ST_CLR
    } irqx_state_e;

    typedef struct packed {
        logic word;
        logic src_inc;
        logic dst_inc;
    } irqx_mode_t;

    // Extract the transfer attributes from a raw mode word
    function automatic irqx_mode_t decode_mode(input logic [15:0] raw);
        irqx_mode_t m;
        m.word    = raw[MODE_WORD_BIT];
        m.src_inc = raw[MODE_SINC_BIT];
        m.dst_inc = raw[MODE_DINC_BIT];
        return m;
    endfunction

endpackage

// File: rtl/irqx_enable_bank.sv
// Per-source transfer enables and request routing.
// Enabled requests go to the engine, the rest go to the CPU.
// A load from en_wr wins over a clear from the sequencer in the same cycle.
module irqx_enable_bank #(
    parameter int NSRC = 4,
    parameter int IW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_req,
    input  logic            en_wr,
    input  logic [NSRC-1:0] en_wdata,
    input  logic            clr_valid,
    input  logic            clr_last,
    input  logic [IW-1:0]   clr_idx,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] eng_req,
    output logic [NSRC-1:0] cpu_irq
);

    // Hold the enable vector; drop a bit when its control block runs out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_wdata;
        end else if (clr_valid && clr_last) begin
            en_q[clr_idx] <= 1'b0;
        end
    end

    // Route each request to the engine or the CPU
    always_comb begin
        eng_req = irq_req & en_q;
        cpu_irq = irq_req & ~en_q;
    end

endmodule

// File: rtl/irqx_pick.sv
// Fixed-priority selector: the lowest-index asserted request wins.
// Purely combinational; the caller samples it only when idle.
module irqx_pick #(
    parameter int NSRC = 4,
    parameter int IW   = 2
) (
    input  logic [NSRC-1:0] req,
    output logic            valid,
    output logic [IW-1:0]   idx
);

    logic [NSRC:0]   seen;
    logic [NSRC-1:0] first;

    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_chain
            assign seen[g+1] = seen[g] | req[g];
            assign first[g]  = req[g] & ~seen[g];
        end
    endgenerate

    assign valid = seen[NSRC];

    // Encode the single winning bit into an index
    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (first[i]) idx = idx | IW'(i);
        end
    end

endmodule

// File: rtl/irqx_sequencer.sv
// Service sequencer: vector read, four control-block reads, data read,
// data write, three write-backs, clear. Every memory access takes two
// cycles: an issue cycle (waits for grant) and a settle cycle in which
// read data is captured. Assumes read data arrives one cycle after issue.
module irqx_sequencer
    import irqx_pkg::*;
#(
    parameter int          NSRC     = 4,
    parameter int          IW       = 2,
    parameter int          AW       = 16,
    parameter logic [15:0] VEC_BASE = 16'h00A0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_valid,
    input  logic [IW-1:0] start_idx,
    input  logic          bus_gnt,
    input  logic [15:0]   mem_rdata,
    output logic          bus_req,
    output logic          mem_en,
    output logic          mem_we,
    output logic          mem_byte,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic          done_valid,
    output logic          done_last,
    output logic [IW-1:0] done_idx
);

    localparam logic [AW-1:0] VEC_BASE_A = AW'(VEC_BASE);

    irqx_state_e   state_q;
    logic          phase_q;
    logic [IW-1:0] idx_q;
    logic [AW-1:0] blk_q;
    logic [15:0]   mode_raw_q;
    logic [AW-1:0] src_q;
    logic [AW-1:0] dst_q;
    logic [15:0]   cnt_q;
    logic [15:0]   data_q;

    irqx_mode_t    mode;
    logic          accessing;
    logic [AW-1:0] step;
    irqx_state_e   next_access;

    assign mode      = decode_mode(mode_raw_q);
    assign accessing = (state_q != ST_IDLE) && (state_q != ST_CLR);
    assign step      = mode.word ? AW'(2) : AW'(1);

    // Order of the access states
    always_comb begin
        unique case (state_q)
            ST_VEC:    next_access = ST_MODE;
            ST_MODE:   next_access = ST_SRC;
            ST_SRC:    next_access = ST_DST;
            ST_DST:    next_access = ST_CNT;
            ST_CNT:    next_access = ST_RDATA;
            ST_RDATA:  next_access = ST_WDATA;
            ST_WDATA:  next_access = ST_WB_SRC;
            ST_WB_SRC: next_access = ST_WB_DST;
            ST_WB_DST: next_access = ST_WB_CNT;
            ST_WB_CNT: next_access = ST_CLR;
            default:   next_access = ST_IDLE;
        endcase
    end

    // Address, direction, size and write data for the current access
    always_comb begin
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_byte  = 1'b0;
        mem_wdata = '0;
        unique case (state_q)
            ST_VEC:    mem_addr = VEC_BASE_A + {{(AW-IW-1){1'b0}}, idx_q, 1'b0};
            ST_MODE:   mem_addr = blk_q + AW'(OFS_MODE);
            ST_SRC:    mem_addr = blk_q + AW'(OFS_SRC);
            ST_DST:    mem_addr = blk_q + AW'(OFS_DST);
            ST_CNT:    mem_addr = blk_q + AW'(OFS_CNT);
            ST_RDATA: begin
                mem_addr = src_q;
                mem_byte = ~mode.word;
            end
            ST_WDATA: begin
                mem_addr  = dst_q;
                mem_we    = 1'b1;
                mem_byte  = ~mode.word;
                mem_wdata = data_q;
            end
            ST_WB_SRC: begin
                mem_addr  = blk_q + AW'(OFS_SRC);
                mem_we    = 1'b1;
                mem_wdata = 16'(src_q);
            end
            ST_WB_DST: begin
                mem_addr  = blk_q + AW'(OFS_DST);
                mem_we    = 1'b1;
                mem_wdata = 16'(dst_q);
            end
            ST_WB_CNT: begin
                mem_addr  = blk_q + AW'(OFS_CNT);
                mem_we    = 1'b1;
                mem_wdata = cnt_q;
            end
            default: ;
        endcase
    end

    assign mem_en     = accessing && !phase_q && bus_gnt;
    assign bus_req    = (state_q != ST_IDLE);
    assign done_valid = (state_q == ST_CLR);
    assign done_last  = (cnt_q == 16'h0000);
    assign done_idx   = idx_q;

    // State and phase progression
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    phase_q <= 1'b0;
                    if (start_valid) begin
                        idx_q   <= start_idx;
                        state_q <= ST_VEC;
                    end
                end
                ST_CLR: state_q <= ST_IDLE;
                default: begin
                    if (!phase_q) begin
                        if (bus_gnt) phase_q <= 1'b1;
                    end else begin
                        phase_q <= 1'b0;
                        state_q <= next_access;
                    end
                end
            endcase
        end
    end

    // Capture read data and apply the post-move updates in the settle cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q      <= '0;
            mode_raw_q <= '0;
            src_q      <= '0;
            dst_q      <= '0;
            cnt_q      <= '0;
            data_q     <= '0;
        end else if (accessing && phase_q) begin
            unique case (state_q)
                ST_VEC:   blk_q      <= AW'(mem_rdata);
                ST_MODE:  mode_raw_q <= mem_rdata;
                ST_SRC:   src_q      <= AW'(mem_rdata);
                ST_DST:   dst_q      <= AW'(mem_rdata);
                ST_CNT:   cnt_q      <= mem_rdata;
                ST_RDATA: data_q     <= mode.word ? mem_rdata : {8'h00, mem_rdata[7:0]};
                ST_WDATA: begin
                    if (mode.src_inc) src_q <= src_q + step;
                    if (mode.dst_inc) dst_q <= dst_q + step;
                    cnt_q <= cnt_q - 16'd1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_xfer_engine.sv
// Top of the interrupt-triggered descriptor transfer engine.
// Routes requests, picks the lowest enabled source when idle, runs one
// service, then pulses the clear line of the served source.
module irq_xfer_engine #(
    parameter int          NSRC     = 4,
    parameter int          AW       = 16,
    parameter logic [15:0] VEC_BASE = 16'h00A0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_req,
    input  logic            en_wr,
    input  logic [NSRC-1:0] en_wdata,
    output logic [NSRC-1:0] en_state,
    output logic [NSRC-1:0] cpu_irq,
    output logic [NSRC-1:0] irq_clr,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic            mem_en,
    output logic            mem_we,
    output logic            mem_byte,
    output logic [AW-1:0]   mem_addr,
    output logic [15:0]     mem_wdata,
    input  logic [15:0]     mem_rdata
);

    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0] eng_req;
    logic            pick_valid;
    logic [IW-1:0]   pick_idx;
    logic            done_valid;
    logic            done_last;
    logic [IW-1:0]   done_idx;

    irqx_enable_bank #(.NSRC(NSRC), .IW(IW)) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .clr_valid (done_valid),
        .clr_last  (done_last),
        .clr_idx   (done_idx),
        .en_q      (en_state),
        .eng_req   (eng_req),
        .cpu_irq   (cpu_irq)
    );

    irqx_pick #(.NSRC(NSRC), .IW(IW)) u_pick (
        .req   (eng_req),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    irqx_sequencer #(.NSRC(NSRC), .IW(IW), .AW(AW), .VEC_BASE(VEC_BASE)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_valid (pick_valid),
        .start_idx   (pick_idx),
        .bus_gnt     (bus_gnt),
        .mem_rdata   (mem_rdata),
        .bus_req     (bus_req),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_byte    (mem_byte),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .done_valid  (done_valid),
        .done_last   (done_last),
        .done_idx    (done_idx)
    );

    // Decode the finishing service into a per-source clear pulse
    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_clr
            assign irq_clr[g] = done_valid && (done_idx == IW'(g));
        end
    endgenerate

endmodule

// File: rtl/irqx_checker.sv
// Protocol checks for irq_xfer_engine, attached by bind below.
module irqx_checker #(
    parameter int NSRC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_req,
    input logic            bus_gnt,
    input logic            mem_en,
    input logic            en_wr,
    input logic [NSRC-1:0] irq_clr,
    input logic [NSRC-1:0] en_state
);

    // R11: no access strobe without a grant
    a_r11_access_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> bus_gnt);

    // R11: every access falls inside a held bus request
    a_r11_access_inside_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> bus_req);

    // R7: at most one source is cleared at a time
    a_r7_clear_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_clr));

    // R7: a clear lasts a single cycle
    a_r7_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_clr) |=> !(|irq_clr));

    // R9: an enable only falls after a load or a clear pulse
    a_r9_enable_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(en_state) & ~en_state)) |-> ($past(en_wr) || (|$past(irq_clr))));

    // R11: the bus request is released only after a clear cycle
    a_r11_req_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> (|$past(irq_clr)));

endmodule

bind irq_xfer_engine irqx_checker #(.NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .mem_en   (mem_en),
    .en_wr    (en_wr),
    .irq_clr  (irq_clr),
    .en_state (en_state)
);

// File: tb/sim_irq_xfer_engine.sv
// Self-checking bench for irq_xfer_engine with a 4 KiB byte memory model
// (addresses folded to 12 bits) and level-request peripherals.
module sim_irq_xfer_engine;

    localparam int NSRC = 4;
    localparam int AW   = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_req = '0;
    logic            en_wr = 1'b0;
    logic [NSRC-1:0] en_wdata = '0;
    logic [NSRC-1:0] en_state, cpu_irq, irq_clr;
    logic            bus_req, bus_gnt = 1'b1;
    logic            mem_en, mem_we, mem_byte;
    logic [AW-1:0]   mem_addr;
    logic [15:0]     mem_wdata;
    logic [15:0]     mem_rdata = '0;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [7:0] mem [0:4095];

    always #2 clk = ~clk;

    irq_xfer_engine #(.NSRC(NSRC), .AW(AW), .VEC_BASE(16'h00A0)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .en_wr(en_wr),
        .en_wdata(en_wdata), .en_state(en_state), .cpu_irq(cpu_irq),
        .irq_clr(irq_clr), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_en(mem_en), .mem_we(mem_we), .mem_byte(mem_byte),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: big-endian words, read data one cycle after the strobe
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                if (mem_byte) mem[mem_addr[11:0]] = mem_wdata[7:0];
                else begin
                    mem[mem_addr[11:0]]         = mem_wdata[15:8];
                    mem[12'(mem_addr[11:0] + 1)] = mem_wdata[7:0];
                end
            end else begin
                mem_rdata <= mem_byte ? {8'h00, mem[mem_addr[11:0]]}
                                      : {mem[mem_addr[11:0]], mem[12'(mem_addr[11:0] + 1)]};
            end
        end
    end

    // Peripherals drop their request when cleared
    always @(negedge clk) begin
        for (int i = 0; i < NSRC; i++) if (irq_clr[i]) irq_req[i] = 1'b0;
    end

    // Stimulus table: mode, src, dst, cnt, data, exp_src, exp_dst, exp_cnt
    localparam logic [127:0] TBL [5] = '{
        {16'h2000, 16'hFEDD, 16'hFC00, 16'h0080, 16'h005A, 16'hFEDD, 16'hFC01, 16'h007F},
        {16'h6000, 16'hF010, 16'hF400, 16'h0003, 16'h00C3, 16'hF011, 16'hF401, 16'h0002},
        {16'hE000, 16'hF020, 16'hF500, 16'h0009, 16'h1234, 16'hF022, 16'hF502, 16'h0008},
        {16'h8000, 16'hF030, 16'hF600, 16'h0002, 16'hABCD, 16'hF030, 16'hF600, 16'h0001},
        {16'h4000, 16'hF040, 16'hF700, 16'h0005, 16'h0071, 16'hF041, 16'hF700, 16'h0004}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic void wr16(input logic [15:0] a, input logic [15:0] v);
        mem[a[11:0]]          = v[15:8];
        mem[12'(a[11:0] + 1)] = v[7:0];
    endfunction

    function automatic logic [15:0] rd16(input logic [15:0] a);
        return {mem[a[11:0]], mem[12'(a[11:0] + 1)]};
    endfunction

    task automatic set_blk(input logic [15:0] b, input logic [15:0] m, s, d, c);
        wr16(b, m); wr16(b + 16'd2, s); wr16(b + 16'd4, d); wr16(b + 16'd6, c);
    endtask

    task automatic set_en(input logic [NSRC-1:0] v);
        @(negedge clk); en_wr = 1'b1; en_wdata = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    // Wait for the next clear pulse; returns 0 on timeout
    task automatic wait_clr(output logic [NSRC-1:0] seen);
        seen = '0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (|irq_clr) begin seen = irq_clr; break; end
        end
        @(negedge clk);
    endtask

    task automatic serve(input int s, output logic [NSRC-1:0] seen);
        @(negedge clk); irq_req[s] = 1'b1;
        wait_clr(seen);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [NSRC-1:0] seen;
        logic [127:0] row;
        int mem_hits;
        for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
        wr16(16'h00A0, 16'hF900);
        wr16(16'h00A2, 16'hFB80);
        wr16(16'h00A4, 16'hF980);
        wr16(16'h00A6, 16'hFA00);

        repeat (3) @(negedge clk);
        chk(bus_req == 1'b0 && mem_en == 1'b0, "R1 bus idle in reset", {bus_req, mem_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_req == 1'b0 && mem_en == 1'b0 && irq_clr == '0, "R1 idle after reset",
            {bus_req, mem_en, irq_clr}, 0);
        chk(en_state == '0 && cpu_irq == '0, "R1 enables clear", {en_state, cpu_irq}, 0);

        // Table walk on source 1 (vector 0x00A2 -> block 0xFB80)
        set_en(4'b0010);
        for (int r = 0; r < 5; r++) begin
            row = TBL[r];
            set_blk(16'hFB80, row[127:112], row[111:96], row[95:80], row[79:64]);
            if (row[127]) wr16(row[111:96], row[63:48]);
            else mem[row[107:96]] = row[55:48];
            wr16(row[95:80], 16'hEEEE);
            serve(1, seen);
            chk(seen == 4'b0010, "R7 clear on served source", seen, 4'b0010);
            if (row[127])
                chk(rd16(row[95:80]) == row[63:48], "R5 word moved", rd16(row[95:80]), row[63:48]);
            else begin
                chk(mem[row[91:80]] == row[55:48], "R2 R4 byte moved", mem[row[91:80]], row[55:48]);
                chk(mem[12'(row[91:80] + 1)] == 8'hEE, "R5 neighbour byte kept",
                    mem[12'(row[91:80] + 1)], 8'hEE);
            end
            chk(rd16(16'hFB82) == row[47:32], "R6 source writeback", rd16(16'hFB82), row[47:32]);
            chk(rd16(16'hFB84) == row[31:16], "R6 destination writeback", rd16(16'hFB84), row[31:16]);
            chk(rd16(16'hFB86) == row[15:0], "R6 count writeback", rd16(16'hFB86), row[15:0]);
            chk(rd16(16'hFB80) == row[127:112], "R3 mode word untouched", rd16(16'hFB80), row[127:112]);
            chk(en_state == 4'b0010, "R9 enable kept while count nonzero", en_state, 4'b0010);
        end

        // R8: disabled source goes to the CPU, no memory traffic
        mem_hits = 0;
        @(negedge clk); irq_req[3] = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (mem_en || bus_req) mem_hits++;
        end
        chk(cpu_irq[3] == 1'b1, "R8 disabled request to CPU", cpu_irq, 4'b1000);
        chk(mem_hits == 0, "R8 no access for disabled source", mem_hits, 0);
        @(negedge clk); irq_req[3] = 1'b0;

        // R10: simultaneous requests on sources 0 and 2
        set_blk(16'hF900, 16'h2000, 16'hF100, 16'hF180, 16'h0004);
        set_blk(16'hF980, 16'h2000, 16'hF110, 16'hF190, 16'h0004);
        mem[12'h100] = 8'h11; mem[12'h110] = 8'h22;
        set_en(4'b0101);
        @(negedge clk); irq_req[0] = 1'b1; irq_req[2] = 1'b1;
        wait_clr(seen);
        chk(seen == 4'b0001, "R10 lowest index first", seen, 4'b0001);
        wait_clr(seen);
        chk(seen == 4'b0100, "R10 higher index second", seen, 4'b0100);
        chk(mem[12'h180] == 8'h11 && mem[12'h190] == 8'h22, "R10 both served",
            {mem[12'h180], mem[12'h190]}, 16'h1122);

        // R11: stall with grant low
        set_blk(16'hFA00, 16'h2000, 16'hF120, 16'hF1A0, 16'h0004);
        mem[12'h120] = 8'h33;
        set_en(4'b1000);
        bus_gnt = 1'b0;
        mem_hits = 0;
        @(negedge clk); irq_req[3] = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (mem_en) mem_hits++;
        end
        chk(bus_req == 1'b1, "R11 request held while stalled", bus_req, 1);
        chk(mem_hits == 0, "R11 no access without grant", mem_hits, 0);
        bus_gnt = 1'b1;
        wait_clr(seen);
        chk(seen == 4'b1000 && mem[12'h1A0] == 8'h33, "R11 completes after grant",
            {seen, mem[12'h1A0]}, {4'b1000, 8'h33});

        // R12 + R9: full 128-byte job from a serial data register
        set_blk(16'hFB80, 16'h2000, 16'hFEDD, 16'hFC00, 16'h0080);
        set_en(4'b0010);
        for (int k = 0; k < 128; k++) begin
            mem[12'hEDD] = 8'(k) ^ 8'h3C;
            serve(1, seen);
        end
        mem_hits = 0;
        for (int k = 0; k < 128; k++)
            if (mem[12'hC00 + 12'(k)] != (8'(k) ^ 8'h3C)) mem_hits++;
        chk(mem_hits == 0, "R12 128 consecutive bytes", mem_hits, 0);
        chk(rd16(16'hFB86) == 16'h0000 && rd16(16'hFB84) == 16'hFC80, "R12 final count and pointer",
            {rd16(16'hFB86), rd16(16'hFB84)}, {16'h0000, 16'hFC80});
        chk(en_state[1] == 1'b0, "R9 enable cleared at zero", en_state, 4'b0000);
        @(negedge clk); irq_req[1] = 1'b1;
        repeat (4) @(negedge clk);
        chk(cpu_irq[1] == 1'b1 && bus_req == 1'b0, "R9 completion request to CPU",
            {cpu_irq, bus_req}, {4'b0010, 1'b0});
        irq_req[1] = 1'b0;

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule